// File: doc/BRIEF.md
# Single-Cycle Datapath Control Decoder

This block is the purely combinational control unit of a single-cycle 32-bit integer datapath. It reads the instruction word fetched in the current cycle together with the two flags returned by the operand comparator. From these it drives every steering and enable signal the datapath needs:

- next-PC source
- immediate format
- register write enable
- comparator signedness
- the two ALU operand sources
- ALU function
- memory direction
- write-back source

The branch decision is made here rather than in the datapath. The decoder picks the branch condition from funct3, inverts the less-than flag for the greater-or-equal forms, and requests an unsigned comparison for the two unsigned branch forms. Any opcode outside the supported set gets outputs that leave architectural state untouched: no register write, a memory read, and a sequential PC.

The decoder has no clock and no storage. Its outputs follow the instruction and the flags within the same cycle.

Top module: `rv_ctrl_decode`

## Requirements

Encodings used throughout:

| Output | Encoding |
|---|---|
| pc_sel | 0 = PC+4, 1 = ALU result |
| imm_sel | 0 = I, 1 = S, 2 = B, 3 = J |
| a_sel | 0 = rs1, 1 = PC |
| b_sel | 0 = rs2, 1 = immediate |
| mem_rw | 0 = read, 1 = write |
| wb_sel | 0 = memory, 1 = ALU, 2 = PC+4 |
| alu_sel | {variant bit, funct3}; 0000 is add, 1000 is subtract, 1101 is arithmetic right shift, other codes are {0, funct3} |

Opcodes, as inst[6:0]:

| Class | Opcode |
|---|---|
| register ALU | 0110011 |
| immediate ALU | 0010011 |
| load | 0000011 |
| store | 0100011 |
| branch | 1100011 |
| jal | 1101111 |
| jalr | 1100111 |

- R1: Register ALU opcode gives reg_wen=1, a_sel=0, b_sel=0, wb_sel=1, mem_rw=0 and pc_sel=0. alu_sel is {inst[30], funct3} when funct3 is 000 or 101, otherwise {0, funct3}.
- R2: Immediate ALU opcode gives imm_sel=0, reg_wen=1, a_sel=0, b_sel=1, wb_sel=1, mem_rw=0 and pc_sel=0. alu_sel is {inst[30], funct3} only for funct3=101, otherwise {0, funct3}. Because of this, a negative addi or xori immediate cannot turn the operation into a subtract.
- R3: Any load (every funct3) gives imm_sel=0, reg_wen=1, a_sel=0, b_sel=1, alu_sel=0000, mem_rw=0, wb_sel=0 and pc_sel=0.
- R4: Store gives imm_sel=1, reg_wen=0, a_sel=0, b_sel=1, alu_sel=0000, mem_rw=1 and pc_sel=0. wb_sel is unspecified.
- R5: Branch opcode gives imm_sel=2, reg_wen=0, a_sel=1, b_sel=1, alu_sel=0000 and mem_rw=0. wb_sel is unspecified.
- R6: For a branch, pc_sel=1 exactly when the condition holds:
  - funct3 000: br_eq=1
  - funct3 001: br_eq=0
  - funct3 100 or 110: br_lt=1
  - funct3 101 or 111: br_lt=0
- R7: br_un is 1 only for a branch with funct3 110 or 111, and 0 for every other instruction.
- R8: jal gives imm_sel=3, reg_wen=1, a_sel=1, b_sel=1, alu_sel=0000, mem_rw=0, wb_sel=2 and pc_sel=1, whatever the flags.
- R9: jalr gives imm_sel=0, reg_wen=1, a_sel=0, b_sel=1, alu_sel=0000, mem_rw=0, wb_sel=2 and pc_sel=1, whatever the flags.
- R10: An unrecognised opcode, or a branch with funct3 010 or 011, gives reg_wen=0, mem_rw=0 and pc_sel=0 for any flag values.
- R11: br_eq and br_lt have no effect on any output unless the opcode is a branch.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| inst | input | 32 | Instruction word of the current cycle |
| br_eq | input | 1 | Comparator flag: operands equal |
| br_lt | input | 1 | Comparator flag: first operand less than second |
| pc_sel | output | 1 | Next-PC source select |
| imm_sel | output | 3 | Immediate format select |
| reg_wen | output | 1 | Register file write enable |
| br_un | output | 1 | Request unsigned less-than comparison |
| a_sel | output | 1 | ALU operand A source |
| b_sel | output | 1 | ALU operand B source |
| alu_sel | output | 4 | ALU function code |
| mem_rw | output | 1 | Data memory direction |
| wb_sel | output | 2 | Register write-back source |

## Verification

Every result is due in the same cycle as its stimulus: no register lies between the instruction or flag inputs and any output. The bench changes inputs on the falling clock edge and samples 2 ns later, well before the next rising edge, so every sample sees settled combinational values. Fields the requirements leave unspecified are masked out of the comparison.

// File: rtl/rv_ctrl_decode.sv
module rv_ctrl_decode (
  input  logic [31:0] inst,
  input  logic        br_eq,
  input  logic        br_lt,
  output logic        pc_sel,
  output logic [2:0]  imm_sel,
  output logic        reg_wen,
  output logic        br_un,
  output logic        a_sel,
  output logic        b_sel,
  output logic [3:0]  alu_sel,
  output logic        mem_rw,
  output logic [1:0]  wb_sel
);

  localparam logic [6:0] OP_REG  = 7'b0110011;
  localparam logic [6:0] OP_IMM  = 7'b0010011;
  localparam logic [6:0] OP_LOAD = 7'b0000011;
  localparam logic [6:0] OP_STOR = 7'b0100011;
  localparam logic [6:0] OP_BRCH = 7'b1100011;
  localparam logic [6:0] OP_JAL  = 7'b1101111;
  localparam logic [6:0] OP_JALR = 7'b1100111;

  localparam logic [2:0] IMM_I = 3'd0;
  localparam logic [2:0] IMM_S = 3'd1;
  localparam logic [2:0] IMM_B = 3'd2;
  localparam logic [2:0] IMM_J = 3'd3;

  localparam logic [1:0] WB_MEM = 2'd0;
  localparam logic [1:0] WB_ALU = 2'd1;
  localparam logic [1:0] WB_PC4 = 2'd2;

  logic [6:0] opcode;
  logic [2:0] f3;
  logic       alt;
  logic       taken;
  logic       unused_fields;

  assign opcode = inst[6:0];
  assign f3     = inst[14:12];
  assign alt    = inst[30];
  assign unused_fields = ^{inst[31], inst[29:15], inst[11:7]};

  always_comb begin
    case (f3)
      3'b000:         taken = br_eq;
      3'b001:         taken = !br_eq;
      3'b100, 3'b110: taken = br_lt;
      3'b101, 3'b111: taken = !br_lt;
      default:        taken = 1'b0;
    endcase
  end

  always_comb begin
    pc_sel  = 1'b0;
    imm_sel = IMM_I;
    reg_wen = 1'b0;
    br_un   = 1'b0;
    a_sel   = 1'b0;
    b_sel   = 1'b0;
    alu_sel = 4'b0000;
    mem_rw  = 1'b0;
    wb_sel  = WB_ALU;
    case (opcode)
      OP_REG: begin
        reg_wen = 1'b1;
        alu_sel = {alt & ((f3 == 3'b000) | (f3 == 3'b101)), f3};
      end
      OP_IMM: begin
        reg_wen = 1'b1;
        b_sel   = 1'b1;
        alu_sel = {alt & (f3 == 3'b101), f3};
      end
      OP_LOAD: begin
        reg_wen = 1'b1;
        b_sel   = 1'b1;
        wb_sel  = WB_MEM;
      end
      OP_STOR: begin
        imm_sel = IMM_S;
        b_sel   = 1'b1;
        mem_rw  = 1'b1;
      end
      OP_BRCH: begin
        imm_sel = IMM_B;
        a_sel   = 1'b1;
        b_sel   = 1'b1;
        br_un   = f3[2] & f3[1];
        pc_sel  = taken;
      end
      OP_JAL: begin
        imm_sel = IMM_J;
        reg_wen = 1'b1;
        a_sel   = 1'b1;
        b_sel   = 1'b1;
        wb_sel  = WB_PC4;
        pc_sel  = 1'b1;
      end
      OP_JALR: begin
        reg_wen = 1'b1;
        b_sel   = 1'b1;
        wb_sel  = WB_PC4;
        pc_sel  = 1'b1;
      end
      default: ;
    endcase
  end

  logic known_op;
  assign known_op = (opcode == OP_REG) || (opcode == OP_IMM) || (opcode == OP_LOAD) ||
                    (opcode == OP_STOR) || (opcode == OP_BRCH) || (opcode == OP_JAL) ||
                    (opcode == OP_JALR);

  always_comb begin
    AST_STORE_NO_WRITEBACK: assert (!(mem_rw && reg_wen)); // R4
    AST_REDIRECT_USES_ADD: assert (!pc_sel || alu_sel == 4'b0000); // R6
    AST_UNSIGNED_ONLY_BRANCH: assert (!br_un || (opcode == OP_BRCH && f3[2])); // R7
    AST_LINK_IMPLIES_JUMP: assert (wb_sel != WB_PC4 || (pc_sel && reg_wen)); // R8
    AST_UNKNOWN_SAFE: assert (known_op || (!reg_wen && !mem_rw && !pc_sel)); // R10
    AST_PC_OPERAND_SRC: assert (!a_sel || (b_sel && !mem_rw)); // R5
  end

endmodule

// File: tb/rv_ctrl_decode_tb_top.sv
module rv_ctrl_decode_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] inst = 32'h0;
  logic        br_eq = 1'b0;
  logic        br_lt = 1'b0;
  logic        pc_sel, reg_wen, br_un, a_sel, b_sel, mem_rw;
  logic [2:0]  imm_sel;
  logic [3:0]  alu_sel;
  logic [1:0]  wb_sel;

  rv_ctrl_decode dut_i (
    .inst(inst), .br_eq(br_eq), .br_lt(br_lt),
    .pc_sel(pc_sel), .imm_sel(imm_sel), .reg_wen(reg_wen), .br_un(br_un),
    .a_sel(a_sel), .b_sel(b_sel), .alu_sel(alu_sel), .mem_rw(mem_rw), .wb_sel(wb_sel)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // packed result: pc_imm(3)_wen_un_a_b_alu(4)_mem_wb(2)
  localparam logic [14:0] FM = 15'b1_111_1_1_1_1_1111_1_11;
  localparam logic [14:0] RM = 15'b1_000_1_1_1_1_1111_1_11;
  localparam logic [14:0] SM = 15'b1_111_1_1_1_1_1111_1_00;
  localparam logic [14:0] UM = 15'b1_000_1_0_0_0_0000_1_00;

  localparam int NV = 30;
  // {inst, br_eq, br_lt, expected, mask}
  localparam logic [63:0] VEC [NV] = '{
    {32'h003100B3, 1'b0, 1'b0, 15'b0_000_1_0_0_0_0000_0_01, RM}, // R1 add
    {32'h403100B3, 1'b1, 1'b1, 15'b0_000_1_0_0_0_1000_0_01, RM}, // R1 sub, R11 flags set
    {32'h403150B3, 1'b0, 1'b0, 15'b0_000_1_0_0_0_1101_0_01, RM}, // R1 sra
    {32'h403170B3, 1'b0, 1'b0, 15'b0_000_1_0_0_0_0111_0_01, RM}, // R1 and, bit30 ignored
    {32'h003130B3, 1'b0, 1'b0, 15'b0_000_1_0_0_0_0011_0_01, RM}, // R1 sltu
    {32'hFCE08793, 1'b1, 1'b0, 15'b0_000_1_0_0_1_0000_0_01, FM}, // R2 addi -50 stays add
    {32'h40315093, 1'b0, 1'b0, 15'b0_000_1_0_0_1_1101_0_01, FM}, // R2 srai
    {32'h00311093, 1'b0, 1'b1, 15'b0_000_1_0_0_1_0001_0_01, FM}, // R2 slli
    {32'hFFF14093, 1'b0, 1'b0, 15'b0_000_1_0_0_1_0100_0_01, FM}, // R2 xori -1
    {32'h00812703, 1'b1, 1'b1, 15'b0_000_1_0_0_1_0000_0_00, FM}, // R3 lw
    {32'h00814703, 1'b0, 1'b0, 15'b0_000_1_0_0_1_0000_0_00, FM}, // R3 lbu
    {32'h00E12423, 1'b1, 1'b1, 15'b0_001_0_0_0_1_0000_1_00, SM}, // R4 sw
    {32'h00208063, 1'b1, 1'b0, 15'b1_010_0_0_1_1_0000_0_00, SM}, // R5 R6 beq taken
    {32'h00208063, 1'b0, 1'b1, 15'b0_010_0_0_1_1_0000_0_00, SM}, // R6 beq not taken
    {32'h00209063, 1'b0, 1'b0, 15'b1_010_0_0_1_1_0000_0_00, SM}, // R6 bne taken
    {32'h00209063, 1'b1, 1'b0, 15'b0_010_0_0_1_1_0000_0_00, SM}, // R6 bne not taken
    {32'h0020C063, 1'b0, 1'b1, 15'b1_010_0_0_1_1_0000_0_00, SM}, // R6 blt taken
    {32'h0020C063, 1'b1, 1'b0, 15'b0_010_0_0_1_1_0000_0_00, SM}, // R6 blt not taken
    {32'h0020D063, 1'b0, 1'b0, 15'b1_010_0_0_1_1_0000_0_00, SM}, // R6 bge taken
    {32'h0020D063, 1'b0, 1'b1, 15'b0_010_0_0_1_1_0000_0_00, SM}, // R6 bge not taken
    {32'h0020E063, 1'b0, 1'b1, 15'b1_010_0_1_1_1_0000_0_00, SM}, // R7 bltu taken
    {32'h0020F063, 1'b1, 1'b0, 15'b1_010_0_1_1_1_0000_0_00, SM}, // R7 bgeu taken
    {32'h0020F063, 1'b0, 1'b1, 15'b0_010_0_1_1_1_0000_0_00, SM}, // R7 bgeu not taken
    {32'h0020A063, 1'b1, 1'b1, 15'b0_010_0_0_1_1_0000_0_00, SM}, // R10 branch funct3 010
    {32'h000000EF, 1'b0, 1'b0, 15'b1_011_1_0_1_1_0000_0_10, FM}, // R8 jal
    {32'h000000EF, 1'b1, 1'b1, 15'b1_011_1_0_1_1_0000_0_10, FM}, // R8 R11 jal flags set
    {32'h000100E7, 1'b1, 1'b0, 15'b1_000_1_0_0_1_0000_0_10, FM}, // R9 jalr
    {32'h000100E7, 1'b0, 1'b1, 15'b1_000_1_0_0_1_0000_0_10, FM}, // R9 jalr other flags
    {32'h000010B7, 1'b1, 1'b1, 15'b0_000_0_0_0_0_0000_0_00, UM}, // R10 unsupported opcode
    {32'h00000000, 1'b1, 1'b0, 15'b0_000_0_0_0_0_0000_0_00, UM}  // R10 all-zero word
  };

  localparam int VREQ [NV] = '{1,1,1,1,1,2,2,2,2,3,3,4,5,6,6,6,6,6,6,6,7,7,7,10,8,8,9,9,10,10};

  function automatic logic [14:0] got_word();
    return {pc_sel, imm_sel, reg_wen, br_un, a_sel, b_sel, alu_sel, mem_rw, wb_sel};
  endfunction

  task automatic apply(input logic [31:0] i, input logic e, input logic l);
    @(negedge clk);
    inst = i; br_eq = e; br_lt = l;
    #2;
  endtask

  task automatic check(input int req, input logic [14:0] exp, input logic [14:0] mask);
    logic [14:0] g;
    g = got_word();
    checks++;
    if ((g & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL R%0d inst=%h eq=%b lt=%b actual=%b expected=%b mask=%b",
               req, inst, br_eq, br_lt, g, exp, mask);
    end
  endtask

  initial begin
    #2;
    // reset state: idle all-zero word must be safe (R10)
    check(10, 15'b0, UM);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][63:32], VEC[v][31], VEC[v][30]);
      check(VREQ[v], VEC[v][29:15], VEC[v][14:0]);
    end
    // R10: every unsupported opcode is safe with both flags set
    for (int op = 0; op < 128; op++) begin
      logic [6:0] o;
      o = op[6:0];
      if (o != 7'h33 && o != 7'h13 && o != 7'h03 && o != 7'h23 &&
          o != 7'h63 && o != 7'h6F && o != 7'h67) begin
        apply({25'h1FFFFFF, o}, 1'b1, 1'b1);
        check(10, 15'b0, UM);
      end
    end
    // R11: flags toggled under a load leave outputs unchanged
    for (int f = 0; f < 4; f++) begin
      apply(32'h00812703, f[0], f[1]);
      check(11, 15'b0_000_1_0_0_1_0000_0_00, FM);
    end
    // R7: branch funct3 011 must not request unsigned compare
    apply(32'h0020B063, 1'b0, 1'b1);
    check(7, 15'b0_010_0_0_1_1_0000_0_00, SM);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule